// File: doc/BRIEF.md
# Comma-Aligning Serial-to-Parallel Deserializer

This block turns a retimed serial bit stream, one bit per rising edge of a bit-rate clock, into 10-bit parallel words. A 10-bit shift window slides over the stream. The block compares the seven oldest bits of that window against the positive-disparity comma pattern. A word is latched at the bit-clock edge where one of two complementary half-rate byte clocks rises. The two clocks take turns, so consecutive words are marked alternately by `rbc1_o` and `rbc0_o`.

When a comma shows up off the current word boundary, or on a boundary where `rbc0_o` would rise, the byte-clock FSM re-frames the stream. It only ever holds the present byte-clock level for extra bit times, so a level is never shortened. Once the block is aligned, every comma word comes out on a rising edge of `rbc1_o`.

The FSM has three states:
- `S_TRACK`: normal counting, with a toggle every 10 bits.
- `S_STRETCH`: the count was restarted by a re-frame. The next boundary toggles and returns to `S_TRACK`.
- `S_SKIP`: the next boundary is suppressed so that the following one makes `rbc1_o` rise. That boundary moves the FSM to `S_STRETCH`.

The FSM has these transitions:
- TRACK/STRETCH→STRETCH: a misaligned comma arrives while `rbc1_o` is high.
- TRACK/STRETCH/SKIP→SKIP: a misaligned comma arrives while `rbc1_o` is low.
- SKIP→STRETCH: the suppressed boundary is reached.
- Any state→TRACK: a normal toggle, or an aligned comma.

Top module: `comma_deser`

## Requirements
- R1: While `rst` is high, and after it, until the first toggle: `rbc1_o`=0, `rbc0_o`=1, `word_o`=0 and `comma_o`=0.
- R2: At each byte-clock rise, `word_o` takes the last 10 received bits. The earliest of them is in bit 9 and the one sampled at that edge is in bit 0.
- R3: `comma_o` is loaded with the word. It is 1 exactly when bits 9..3 of that word are 0011111.
- R4: `rbc0_o` is always the complement of `rbc1_o`.
- R5: Every byte-clock level lasts at least 10 bit cycles. With no comma in the stream, every level lasts exactly 10. When commas are at least two words apart, no level lasts more than 29.
- R6: `word_o` and `comma_o` change only at an edge where `rbc1_o` or `rbc0_o` rises, and they load at every such edge.
- R7: A word with `comma_o`=1 is presented only on a rising edge of `rbc1_o`. After comma/data ordered sets start at any bit offset, the comma of the second set is presented.
- R8: A comma that completes on a boundary where `rbc1_o` is about to rise causes no stretch: all levels stay 10 bit cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_i | input | 1 | Retimed serial data, one bit per clock |
| word_o | output | 10 | Recovered parallel word, earliest bit in bit 9 |
| comma_o | output | 1 | Comma flag registered with `word_o` |
| rbc1_o | output | 1 | Byte clock whose rising edge marks comma words |
| rbc0_o | output | 1 | Complementary byte clock |

## Verification
A wrong bit count or a wrong state shows at the ports as a byte-clock level that is not 10 bits long. It appears within one level, so at most 29 bit cycles after the fault. A misframed window shows as a `word_o` that differs from the last ten bits sent, at the very next rise. A wrong re-frame choice shows as a comma word marked by `rbc0_o`, or as a missing comma in the second ordered set. That is visible within two words.

// File: rtl/cds_pkg.sv
package cds_pkg;

    // Byte-clock framing states
    typedef enum logic [1:0] {
        S_TRACK   = 2'd0,  // normal: toggle every word
        S_STRETCH = 2'd1,  // count restarted by re-frame, next boundary toggles
        S_SKIP    = 2'd2   // next boundary suppressed so rbc1 rises on the comma
    } bc_state_e;

endpackage

// File: rtl/cds_shifter.sv
module cds_shifter #(
    parameter int        WORD_W = 10,
    parameter int        PAT_W  = 7,
    parameter logic [PAT_W-1:0] PAT = 7'b0011111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_i,
    output logic [WORD_W-1:0] win_next_o,
    output logic              comma_next_o
);

    logic [WORD_W-1:0] win_q;

    // Window after this edge: oldest bit at the top
    always_comb begin
        win_next_o   = {win_q[WORD_W-2:0], ser_i};
        comma_next_o = (win_next_o[WORD_W-1 -: PAT_W] == PAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            win_q <= win_next_o;
        end
    end

endmodule

// File: rtl/cds_byteclk_fsm.sv
module cds_byteclk_fsm
    import cds_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic comma_i,
    output logic rbc1_o,
    output logic rbc0_o,
    output logic load_o
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam int RUN_W = CNT_W + 3;

    bc_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic            rbc1_q, rbc1_d;
    logic            rbc0_q;
    logic            at_edge, aligned_comma, realign;

    always_comb begin
        at_edge       = (cnt_q == LAST);
        aligned_comma = comma_i && at_edge && !rbc1_q;
        realign       = comma_i && !aligned_comma;
    end

    // Next-state process
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q + 1'b1;
        rbc1_d = rbc1_q;
        unique case (st_q)
            S_TRACK, S_STRETCH: begin
                if (realign) begin
                    cnt_d = '0;
                    st_d  = rbc1_q ? S_STRETCH : S_SKIP;
                end else if (at_edge) begin
                    cnt_d  = '0;
                    rbc1_d = !rbc1_q;
                    st_d   = S_TRACK;
                end
            end
            S_SKIP: begin
                if (realign) begin
                    cnt_d = '0;
                    st_d  = rbc1_q ? S_STRETCH : S_SKIP;
                end else if (aligned_comma) begin
                    cnt_d  = '0;
                    rbc1_d = !rbc1_q;
                    st_d   = S_TRACK;
                end else if (at_edge) begin
                    cnt_d = '0;
                    st_d  = S_STRETCH;
                end
            end
            default: begin
                cnt_d = '0;
                st_d  = S_TRACK;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_TRACK;
            cnt_q  <= '0;
            rbc1_q <= 1'b0;
            rbc0_q <= 1'b1;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            rbc1_q <= rbc1_d;
            rbc0_q <= !rbc1_d;
        end
    end

    // Output process
    always_comb begin
        rbc1_o = rbc1_q;
        rbc0_o = rbc0_q;
        load_o = (rbc1_d != rbc1_q);
    end

    // Level-length monitor for the assertions below
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst || load_o) begin
            run_q <= RUN_W'(1);
        end else if (run_q != '1) begin
            run_q <= run_q + 1'b1;
        end
    end

    p_complement_r4: assert property (@(posedge clk) disable iff (rst)
        rbc1_q != rbc0_q);

    p_min_level_r5: assert property (@(posedge clk) disable iff (rst)
        load_o |-> (run_q >= RUN_W'(WORD_W)));

    p_comma_on_rbc1_r7: assert property (@(posedge clk) disable iff (rst)
        (comma_i && load_o) |-> !rbc1_q);

    p_aligned_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_TRACK && aligned_comma) |=> (st_q == S_TRACK && cnt_q == '0 && rbc1_q));

endmodule

// File: rtl/cds_word_reg.sv
module cds_word_reg #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              comma_i,
    input  logic              rbc1_i,
    input  logic              rbc0_i,
    output logic [WORD_W-1:0] word_o,
    output logic              comma_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o  <= '0;
            comma_o <= 1'b0;
        end else if (load_i) begin
            word_o  <= word_i;
            comma_o <= comma_i;
        end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable({word_o, comma_o}) |-> ($rose(rbc1_i) || $rose(rbc0_i)));

endmodule

// File: rtl/comma_deser.sv
module comma_deser #(
    parameter int WORD_W = 10,
    parameter int PAT_W  = 7,
    parameter logic [PAT_W-1:0] PAT = 7'b0011111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_i,
    output logic [WORD_W-1:0] word_o,
    output logic              comma_o,
    output logic              rbc1_o,
    output logic              rbc0_o
);

    logic [WORD_W-1:0] win_next;
    logic              comma_next;
    logic              load;

    cds_shifter #(.WORD_W(WORD_W), .PAT_W(PAT_W), .PAT(PAT)) u_shift (
        .clk          (clk),
        .rst          (rst),
        .ser_i        (ser_i),
        .win_next_o   (win_next),
        .comma_next_o (comma_next)
    );

    cds_byteclk_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .comma_i (comma_next),
        .rbc1_o  (rbc1_o),
        .rbc0_o  (rbc0_o),
        .load_o  (load)
    );

    cds_word_reg #(.WORD_W(WORD_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .word_i  (win_next),
        .comma_i (comma_next),
        .rbc1_i  (rbc1_o),
        .rbc0_i  (rbc0_o),
        .word_o  (word_o),
        .comma_o (comma_o)
    );

endmodule

// File: tb/comma_deser_tb_top.sv
module comma_deser_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] COMMA_W = 10'b0011111010;
    localparam logic [9:0] DATA_W  = 10'b1010101010;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sin = 1'b0;
    logic [9:0] word;
    logic       comma, rbc1, rbc0;

    comma_deser dut_i (
        .clk(clk), .rst(rst), .ser_i(sin),
        .word_o(word), .comma_o(comma), .rbc1_o(rbc1), .rbc0_o(rbc0)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [9:0] hist, prev_word;
    logic prev1, prev_comma;
    int  len;
    int  comma_loads;
    bit  mode_quiet, mode_dir, stretched;

    function automatic bit is_comma(input logic [9:0] w);
        return w[9:3] == 7'b0011111;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic send_bit(input logic b);
        sin = b;
        @(posedge clk);
        hist = {hist[8:0], b};
        len++;
        @(negedge clk);
        check(rbc1 != rbc0, "R4", "complement", {rbc1, rbc0}, {rbc1, ~rbc1});
        if (rbc1 != prev1) begin
            check(len >= 10, "R5", "level too short", len, 10);
            if (mode_quiet) check(len == 10, "R5/R8", "level length", len, 10);
            if (mode_dir)   check(len <= 29, "R5", "level too long", len, 29);
            if (len != 10) stretched = 1;
            check(word == hist, "R2", "word", word, hist);
            check(comma == is_comma(hist), "R3", "comma flag", comma, is_comma(hist));
            if (comma) begin
                comma_loads++;
                check(rbc1 == 1'b1, "R7", "comma on rbc1 rise", rbc1, 1);
            end
            len = 0;
        end else begin
            check({word, comma} == {prev_word, prev_comma}, "R6", "hold",
                  {word, comma}, {prev_word, prev_comma});
        end
        prev1 = rbc1; prev_word = word; prev_comma = comma;
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 9; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic do_reset();
        rst = 1; sin = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({rbc1, rbc0, word, comma} == {1'b0, 1'b1, 10'd0, 1'b0}, "R1", "reset state",
              {rbc1, rbc0, word, comma}, {1'b0, 1'b1, 10'd0, 1'b0});
        rst = 0;
        hist = '0; prev_word = '0; prev_comma = 0; prev1 = 0;
        len = 0; comma_loads = 0; stretched = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; tests++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        mode_quiet = 0; mode_dir = 0;
        @(negedge clk);

        // R5: filler only, every level exactly 10
        do_reset();
        mode_quiet = 1;
        for (int i = 0; i < 12; i++) send_word(DATA_W);
        check(rbc1 == 1'b0 || rbc1 == 1'b1, "R1", "post-reset clock known", rbc1, rbc1);
        mode_quiet = 0;

        // R8: comma completes on first boundary where rbc1 rises
        do_reset();
        mode_quiet = 1;
        for (int k = 0; k < 3; k++) begin send_word(COMMA_W); send_word(DATA_W); end
        send_word(DATA_W); send_word(DATA_W);
        mode_quiet = 0;
        check(comma_loads == 3, "R8", "aligned commas presented", comma_loads, 3);
        check(!stretched, "R8", "no stretch", stretched, 0);

        // R7/R5: ordered sets at every bit offset
        for (int off = 0; off < 20; off++) begin
            do_reset();
            mode_dir = 1;
            for (int j = 0; j < off; j++) send_bit(j[0] ? 1'b0 : 1'b1);
            for (int k = 0; k < 3; k++) begin send_word(COMMA_W); send_word(DATA_W); end
            send_word(DATA_W); send_word(DATA_W);
            mode_dir = 0;
            check(comma_loads >= 2, "R7", "second comma presented", comma_loads, 2);
        end

        // Random stream with injected ordered sets
        do_reset();
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 6) == 0) begin
                send_word(COMMA_W); send_word(DATA_W);
            end else begin
                send_word(10'($urandom));
            end
        end

        finish_run();
    end

endmodule